// File: doc/BRIEF.md
# SD Short Response Receiver

This block captures the 48-bit short response that a card sends back on the command line after a command. Software arms it by pulsing `arm_set`. While armed, the receiver watches the command line on each bit strobe and takes the first low level it samples as the start of a frame. From that bit onward it shifts in 48 bits. The first 40 of them, the start bit included, go into a 40-bit response value that reads as five bytes. The next seven are the received CRC-7, and the last one is the end bit.

When the last bit arrives, the receiver compares a CRC-7 it has computed over the 40 stored bits with the seven received check bits. It also checks that the end bit is high, and reports each outcome in its own flag. It then drops its armed bit by itself and raises `done` for one clock. If no start bit comes within a fixed number of strobes, it sets a no-response flag and disarms.

Top module: `sd_rsp_rx`

## Requirements
- R1: A one-cycle `arm_set` while `arm_q` is low sets `arm_q` on the next clock and clears `crc_err`, `frame_err` and `no_rsp`. An `arm_set` while `arm_q` is high is ignored.
- R2: While armed and waiting, the command line is sampled only in cycles where `sample_en` is high. The first sample that reads 0 is frame bit 0. A low level without a strobe has no effect.
- R3: A frame is exactly 48 strobed bits counted from the start bit. The clock edge that samples bit 47 clears `arm_q` and raises `done` for exactly one cycle.
- R4: Frame bits 0 to 39 appear in `rsp_data` at completion, with frame bit 0 in `rsp_data[39]` and bit 39 in `rsp_data[0]`. Response byte 1 is therefore `rsp_data[39:32]`, and byte 5 is `rsp_data[7:0]`.
- R5: CRC-7 with polynomial x^7+x^3+1 and seed 0 is computed over frame bits 0 to 39, feeding each bit in arrival order. Frame bits 40 to 46 carry the check bits, most significant first. `crc_err` is set at completion exactly when the two values differ.
- R6: `frame_err` is set at completion exactly when frame bit 47, the end bit, is sampled as 0. This is independent of the CRC result.
- R7: While armed and waiting, the 64th strobe that samples 1 with no start bit seen disarms the receiver and sets `no_rsp`. After 63 such strobes the receiver is still armed.
- R8: While `arm_q` is low, no activity on `cmd_in` or `sample_en` changes `rsp_data`, `crc_err`, `frame_err` or `no_rsp`.
- R9: After reset, `arm_q`, `done`, all flags and `rsp_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe marking a command-line bit sample |
| cmd_in | input | 1 | Command line level from the card |
| arm_set | input | 1 | Software pulse that arms capture |
| arm_q | output | 1 | Armed (response-input enable) bit, self-clearing |
| done | output | 1 | One-cycle pulse when a full frame has been taken |
| rsp_data | output | 40 | Stored first 40 frame bits, first bit at the MSB |
| crc_err | output | 1 | CRC-7 mismatch on the last frame |
| frame_err | output | 1 | End bit of the last frame was 0 |
| no_rsp | output | 1 | Timeout expired with no start bit |

## Verification
The checker assumes that `arm_set` and `sample_en` are single-cycle pulses that are synchronous to `clk`. It also assumes that `cmd_in` is steady in any cycle where a strobe samples it. The bench drives every input on the falling edge and never holds a strobe high for two cycles in a row, so each strobe takes exactly one bit. Frames always begin with a 0 start bit, so the stored MSB is 0 as the block expects. Re-arm pulses in the middle of a frame are placed so that they test the ignore rule without breaking the one-cycle pulse assumption.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

    // One serial step of a CRC register: feed one bit, MSB-out feedback.
    function automatic logic [6:0] crc7_step(input logic [6:0] cur, input logic din);
        logic fb;
        logic [6:0] nxt;
        fb  = din ^ cur[6];
        nxt = {cur[5:0], 1'b0};
        if (fb) nxt = nxt ^ 7'h09;
        return nxt;
    endfunction

endpackage

// File: rtl/sd_rsp_crc7.sv
module sd_rsp_crc7 #(
    parameter int          CRC_W = 7,
    parameter logic [CRC_W-1:0] SEED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    import sd_rsp_pkg::*;

    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)      crc_d = SEED;
        else if (en)  crc_d = crc7_step(crc_q, bit_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= SEED;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sd_rsp_shreg.sv
module sd_rsp_shreg #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    generate
        if (W == 1) begin : g_one
            always_comb sh_d = en ? bit_in : sh_q;
        end else begin : g_many
            always_comb sh_d = en ? {sh_q[W-2:0], bit_in} : sh_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q;
endmodule

// File: rtl/sd_rsp_tmo.sv
module sd_rsp_tmo #(
    parameter int TICKS = 64,
    localparam int TW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    assign expired = tick && (cnt_q == TW'(TICKS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (expired)       cnt_d = '0;
        else if (tick)          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx #(
    parameter int FRAME_BITS = 48,
    parameter int STORE_BITS = 40,
    parameter int CRC_W      = 7,
    parameter int TMO_TICKS  = 64,
    localparam int CW        = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en,
    input  logic                  cmd_in,
    input  logic                  arm_set,
    output logic                  arm_q,
    output logic                  done,
    output logic [STORE_BITS-1:0] rsp_data,
    output logic                  crc_err,
    output logic                  frame_err,
    output logic                  no_rsp
);
    import sd_rsp_pkg::*;

    typedef struct packed {
        rx_state_e             st;
        logic [CW-1:0]         bitcnt;
        logic                  done;
        logic                  crc_err;
        logic                  frame_err;
        logic                  no_rsp;
        logic [STORE_BITS-1:0] rsp;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic                  accept_arm;
    logic                  start_seen;
    logic                  data_shift;
    logic                  crc_shift;
    logic                  last_bit;
    logic                  tmo_tick;
    logic                  tmo_hit;
    logic [STORE_BITS-1:0] data_q;
    logic [CRC_W-1:0]      crc_calc;
    logic [CRC_W-1:0]      crc_rx;

    assign accept_arm = arm_set && (r_q.st == ST_IDLE);
    assign start_seen = sample_en && !cmd_in && (r_q.st == ST_WAIT);
    assign data_shift = start_seen ||
                        (sample_en && (r_q.st == ST_SHIFT) && (r_q.bitcnt < CW'(STORE_BITS)));
    assign crc_shift  = sample_en && (r_q.st == ST_SHIFT) &&
                        (r_q.bitcnt >= CW'(STORE_BITS)) && (r_q.bitcnt < CW'(FRAME_BITS - 1));
    assign last_bit   = sample_en && (r_q.st == ST_SHIFT) && (r_q.bitcnt == CW'(FRAME_BITS - 1));
    assign tmo_tick   = sample_en && cmd_in && (r_q.st == ST_WAIT);

    sd_rsp_shreg #(.W(STORE_BITS)) u_data (
        .clk(clk), .rst_n(rst_n), .en(data_shift), .bit_in(cmd_in), .q(data_q)
    );

    sd_rsp_shreg #(.W(CRC_W)) u_crc_rx (
        .clk(clk), .rst_n(rst_n), .en(crc_shift), .bit_in(cmd_in), .q(crc_rx)
    );

    sd_rsp_crc7 #(.CRC_W(CRC_W), .SEED('0)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(accept_arm), .en(data_shift),
        .bit_in(cmd_in), .crc(crc_calc)
    );

    sd_rsp_tmo #(.TICKS(TMO_TICKS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(accept_arm), .tick(tmo_tick), .expired(tmo_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept_arm) begin
                    r_d.st        = ST_WAIT;
                    r_d.bitcnt    = '0;
                    r_d.crc_err   = 1'b0;
                    r_d.frame_err = 1'b0;
                    r_d.no_rsp    = 1'b0;
                end
            end
            ST_WAIT: begin
                if (tmo_hit) begin
                    r_d.st     = ST_IDLE;
                    r_d.no_rsp = 1'b1;
                end else if (start_seen) begin
                    r_d.st     = ST_SHIFT;
                    r_d.bitcnt = CW'(1);
                end
            end
            ST_SHIFT: begin
                if (last_bit) begin
                    r_d.st        = ST_IDLE;
                    r_d.done      = 1'b1;
                    r_d.rsp       = data_q;
                    r_d.crc_err   = (crc_calc != crc_rx);
                    r_d.frame_err = !cmd_in;
                end else if (sample_en) begin
                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign arm_q     = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign rsp_data  = r_q.rsp;
    assign crc_err   = r_q.crc_err;
    assign frame_err = r_q.frame_err;
    assign no_rsp    = r_q.no_rsp;
endmodule

// File: rtl/sd_rsp_rx_chk.sv
module sd_rsp_rx_chk #(
    parameter int STORE_BITS = 40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sample_en,
    input logic                  arm_set,
    input logic                  arm_q,
    input logic                  done,
    input logic [STORE_BITS-1:0] rsp_data,
    input logic                  crc_err,
    input logic                  frame_err,
    input logic                  no_rsp
);
    p_arm_on_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_set && !arm_q) |=> arm_q);

    p_disarm_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !arm_q);

    p_done_from_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(arm_q) && $past(sample_en)));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_noresp_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_rsp) |-> (!arm_q && $past(arm_q)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && !arm_set) |=> ($stable(rsp_data) && $stable(crc_err) &&
                                  $stable(frame_err) && $stable(no_rsp)));
endmodule

bind sd_rsp_rx sd_rsp_rx_chk #(.STORE_BITS(STORE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .arm_set(arm_set),
    .arm_q(arm_q), .done(done), .rsp_data(rsp_data), .crc_err(crc_err),
    .frame_err(frame_err), .no_rsp(no_rsp)
);

// File: tb/sd_rsp_rx_bench.sv
module sd_rsp_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic        cmd_in = 1'b1;
    logic        arm_set = 1'b0;
    logic        arm_q, done, crc_err, frame_err, no_rsp;
    logic [39:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    sd_rsp_rx u_sd_rsp_rx (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .cmd_in(cmd_in),
        .arm_set(arm_set), .arm_q(arm_q), .done(done), .rsp_data(rsp_data),
        .crc_err(crc_err), .frame_err(frame_err), .no_rsp(no_rsp)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = d[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic tick(input logic b);
        @(negedge clk); cmd_in = b; sample_en = 1'b1;
        @(negedge clk); sample_en = 1'b0; cmd_in = 1'b1;
    endtask

    task automatic arm();
        @(negedge clk); arm_set = 1'b1;
        @(negedge clk); arm_set = 1'b0;
    endtask

    task automatic frame(input logic [39:0] d, input int lead, input logic [6:0] cx,
                         input logic endb, input bit rearm_mid);
        logic [6:0] c;
        arm();
        chk(arm_q == 1'b1, "R1 arm", arm_q, 1);
        chk(no_rsp == 0 && crc_err == 0 && frame_err == 0, "R1 flags cleared",
            {no_rsp, crc_err, frame_err}, 0);
        repeat (lead) tick(1'b1);
        for (int i = 39; i >= 0; i--) begin
            tick(d[i]);
            if (rearm_mid && i == 20) arm();
        end
        c = ref_crc(d) ^ cx;
        for (int i = 6; i >= 0; i--) tick(c[i]);
        tick(endb);
        chk(done == 1'b1, "R3 done pulse", done, 1);
        chk(arm_q == 1'b0, "R3 self clear", arm_q, 0);
        chk(rsp_data == d, "R4 stored bytes", rsp_data, d);
        chk(crc_err == (cx != 0), "R5 crc flag", crc_err, (cx != 0));
        chk(frame_err == !endb, "R6 end bit", frame_err, !endb);
        @(negedge clk);
        chk(done == 1'b0, "R3 done one cycle", done, 0);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [39:0] d;
        logic [39:0] keep;
        repeat (3) @(negedge clk);
        chk(arm_q == 0 && done == 0 && rsp_data == 0 && crc_err == 0 && frame_err == 0 && no_rsp == 0,
            "R9 reset state", {arm_q, done, crc_err, frame_err, no_rsp, rsp_data}, 0);
        rst_n = 1'b1;

        // good frames with varied content and lead-in
        for (int k = 0; k < 40; k++) begin
            seed = nxt(seed); d[38:7] = seed;
            seed = nxt(seed); d[6:0] = seed[6:0];
            d[39] = 1'b0;
            if (k == 0) d = 40'h0;
            if (k == 1) d = 40'h7F_FFFF_FFFF;
            frame(d, k % 5, 7'h0, 1'b1, k == 3);
        end
        // single-bit CRC corruption at each position
        for (int p = 0; p < 7; p++) begin
            seed = nxt(seed);
            d = {1'b0, seed[31:0], seed[6:0]};
            frame(d, 2, 7'(1 << p), 1'b1, 1'b0);
        end
        // bad end bit, good CRC; then both bad
        frame(40'h48_0000_0900, 1, 7'h0, 1'b0, 1'b0);
        frame(40'h01_2345_6789, 0, 7'h55, 1'b0, 1'b0);

        // R2: low level without strobe ignored; R7: 63 idle strobes keep armed
        arm();
        @(negedge clk); cmd_in = 1'b0;
        repeat (3) @(negedge clk);
        cmd_in = 1'b1;
        repeat (63) tick(1'b1);
        chk(arm_q == 1'b1, "R2 no start without strobe / R7 63 ticks", arm_q, 1);
        chk(no_rsp == 1'b0, "R7 no timeout at 63", no_rsp, 0);
        tick(1'b1);
        chk(arm_q == 1'b0, "R7 disarm at 64", arm_q, 0);
        chk(no_rsp == 1'b1, "R7 no_rsp set", no_rsp, 1);

        // R8: unarmed activity ignored
        keep = rsp_data;
        for (int i = 0; i < 48; i++) tick(i[0]);
        chk(rsp_data == keep, "R8 rsp held", rsp_data, keep);
        chk(no_rsp == 1 && crc_err == 0 && arm_q == 0, "R8 flags held",
            {no_rsp, crc_err, arm_q}, 3'b100);

        // re-arm clears no_rsp, timeout restarted; a frame after timeout works
        frame(40'h3C_A5A5_0F0F, 60, 7'h0, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule